// File: doc/BRIEF.md
# Receive Control Register Bank with Timed Command Queue

This block holds the control settings for a receive signal-processing path. A write-only bus (strobe, 8-bit address, 32-bit data) updates a six-word window that starts at address 160. Three words are plain storage: a 32-bit phase-increment word for the down-converter, a pair of 16-bit I/Q scale factors, and the decimation rate minus one. Each holds its value until the next write to it and drives its outputs directly.

Two words work together to form timed receive commands. A write to the quantity word only stages it. A write to the time word takes the written timestamp and, in the same cycle, enqueues the 64-bit pair {timestamp, staged quantity} into a four-entry FIFO. A downstream consumer reads the FIFO head through a valid/ready port: the head entry leaves on any cycle where `cmd_valid` and `cmd_ready` are both high. While an entry is waiting, `cmd_data` does not change. The bus side cannot be stalled, so a command that arrives while the FIFO is full is dropped and a sticky overflow flag is set.

The last word is a write-anything strobe that clears a sticky overrun flag. The datapath sets this flag with a one-cycle pulse.

Top module: `rx_ctrl_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all stored words, the staged quantity, the FIFO (`cmd_valid`=0, `cmd_empty`=1, `cmd_full`=0), `cmd_overflow` and `ovr_flag`.
- R2: A write to address 160 loads `wr_data` into `tune_word`, which is visible after that clock edge.
- R3: A write to address 161 loads `scale_i` from `wr_data[31:16]` and `scale_q` from `wr_data[15:0]`.
- R4: A write to address 162 loads `decim_m1` with `wr_data`, so that the rate is the value plus one.
- R5: A write to address 164 only stages the quantity word, with the line count in bits 31:9 and the lines per frame in bits 8:0. It pushes nothing, and the next command carries it.
- R6: A write to address 163 enqueues {`wr_data`, staged quantity}, with the timestamp in bits 63:32 and the quantity in bits 31:0. If the FIFO was empty, the entry is at `cmd_data` with `cmd_valid` high after that edge.
- R7: The FIFO holds 4 entries and delivers them in the order they were written. An entry is removed when `cmd_valid` && `cmd_ready`. `cmd_ready` while empty has no effect. `cmd_full` is high exactly when 4 entries are held, and `cmd_empty` exactly when none are held.
- R8: A push while full is dropped and sets `cmd_overflow`, which stays set until reset. A push and a pop in the same cycle on a full FIFO are both performed.
- R9: A one-cycle `ovr_pulse` sets `ovr_flag`. Any write to address 165 clears it, whatever the data. If a set and a clear happen in the same cycle, the flag ends up set.
- R10: Writes to addresses outside 160..165, and bus cycles with `wr_en` low, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus word address |
| wr_data | input | 32 | Bus write data |
| ovr_pulse | input | 1 | One-cycle overrun event from the datapath |
| cmd_ready | input | 1 | Consumer accepts the FIFO head |
| tune_word | output | 32 | Down-conversion phase increment |
| scale_i | output | 16 | I scale factor |
| scale_q | output | 16 | Q scale factor |
| decim_m1 | output | 32 | Decimation rate minus one |
| cmd_data | output | 64 | FIFO head: timestamp 63:32, quantity 31:0 |
| cmd_valid | output | 1 | FIFO head holds an entry |
| cmd_empty | output | 1 | FIFO holds no entry |
| cmd_full | output | 1 | FIFO holds 4 entries |
| cmd_overflow | output | 1 | Sticky: a command was dropped |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `rst` is asserted at the first clock edge and that `ovr_pulse` and `cmd_ready` are plain synchronous levels. Beyond that they assume nothing about how bus writes and pops are ordered. The stimulus changes every input only on the falling edge and holds reset over the first edges. It deliberately covers the legal but awkward cases: `cmd_ready` while empty, pushes into a full FIFO, a push and a pop in the same cycle when full, and a set and a clear of the overrun flag in the same cycle. It also sweeps all 256 addresses.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int WIN_WORDS = 6;
  localparam int OFS_TUNE  = 0;
  localparam int OFS_SCALE = 1;
  localparam int OFS_DECIM = 2;
  localparam int OFS_TIME  = 3;
  localparam int OFS_QTY   = 4;
  localparam int OFS_OVCLR = 5;
  localparam int N_STORE   = 4;

  typedef struct packed {
    logic [22:0] lines;
    logic [8:0]  per_frame;
  } qty_t;

  typedef struct packed {
    logic [31:0] stamp;
    qty_t        qty;
  } rx_cmd_t;

  function automatic int store_offset(input int idx);
    case (idx)
      0:       return OFS_TUNE;
      1:       return OFS_SCALE;
      2:       return OFS_DECIM;
      default: return OFS_QTY;
    endcase
  endfunction
endpackage

// File: rtl/rxc_wr_decode.sv
module rxc_wr_decode #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 160,
  parameter int NWORDS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NWORDS-1:0] sel
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(BASE + g);
    assign sel[g] = wr_en && (wr_addr == HIT);
  end

  p_sel_needs_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (|sel) |-> wr_en);
  p_sel_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/rxc_field_reg.sv
module rxc_field_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  p_hold_without_load_r10: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
endmodule

// File: rtl/rxc_sticky.sv
module rxc_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/rxc_cmd_fifo.sv
module rxc_cmd_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] head,
  output logic         valid,
  output logic         empty,
  output logic         full,
  output logic         dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop_fire, push_fire;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_MAX);
  assign valid     = !empty;
  assign head      = mem[rp];
  assign pop_fire  = pop_req && !empty;
  assign push_fire = push && (!full || pop_fire);
  assign dropped   = push && !push_fire;

  always_ff @(posedge clk) begin
    if (push_fire) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_fire) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (pop_fire)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      case ({push_fire, pop_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty);
  p_head_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !pop_req) |=> (valid && $stable(head)));
  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop_req) |=> (full && $stable(head)));
  p_full_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop_req) |=> full);
endmodule

// File: rtl/rx_ctrl_bank.sv
module rx_ctrl_bank #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int BASE       = 160,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                ovr_pulse,
  input  logic                cmd_ready,
  output logic [DATA_W-1:0]   tune_word,
  output logic [DATA_W/2-1:0] scale_i,
  output logic [DATA_W/2-1:0] scale_q,
  output logic [DATA_W-1:0]   decim_m1,
  output logic [2*DATA_W-1:0] cmd_data,
  output logic                cmd_valid,
  output logic                cmd_empty,
  output logic                cmd_full,
  output logic                cmd_overflow,
  output logic                ovr_flag
);
  import rxc_pkg::*;

  localparam int HALF = DATA_W / 2;
  localparam int CMDW = 2 * DATA_W;

  logic [WIN_WORDS-1:0] sel;
  logic [DATA_W-1:0]    store_q [N_STORE];
  logic [DATA_W-1:0]    qty_staged;
  logic [CMDW-1:0]      push_word;
  logic                 drop_evt;

  rxc_wr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NWORDS(WIN_WORDS)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .sel(sel)
  );

  for (genvar g = 0; g < N_STORE; g++) begin : g_store
    localparam int OFS = store_offset(g);
    rxc_field_reg #(.W(DATA_W)) u_reg (
      .clk(clk), .rst(rst), .ld(sel[OFS]), .d(wr_data), .q(store_q[g])
    );
  end

  assign tune_word  = store_q[0];
  assign scale_i    = store_q[1][DATA_W-1:HALF];
  assign scale_q    = store_q[1][HALF-1:0];
  assign decim_m1   = store_q[2];
  assign qty_staged = store_q[3];
  assign push_word  = {wr_data, qty_staged};

  rxc_cmd_fifo #(.W(CMDW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(sel[OFS_TIME]), .push_data(push_word),
    .pop_req(cmd_ready), .head(cmd_data), .valid(cmd_valid),
    .empty(cmd_empty), .full(cmd_full), .dropped(drop_evt)
  );

  rxc_sticky u_ovf (
    .clk(clk), .rst(rst), .set(drop_evt), .clr(1'b0), .flag(cmd_overflow)
  );

  rxc_sticky u_ovr (
    .clk(clk), .rst(rst), .set(ovr_pulse), .clr(sel[OFS_OVCLR]), .flag(ovr_flag)
  );

  p_tune_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(BASE + OFS_TUNE)) |=> tune_word == $past(wr_data));
  p_scale_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(BASE + OFS_SCALE)) |=> {scale_i, scale_q} == $past(wr_data));
  p_qty_no_push_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_empty && wr_en && wr_addr == ADDR_W'(BASE + OFS_QTY)) |=> cmd_empty);
  p_push_empty_head_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_empty && wr_en && wr_addr == ADDR_W'(BASE + OFS_TIME))
      |=> (cmd_valid && cmd_data == {$past(wr_data), $past(qty_staged)}));
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_overflow |=> cmd_overflow);
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_full && cmd_empty));
endmodule

// File: tb/rx_ctrl_bank_test.sv
module rx_ctrl_bank_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        ovr_pulse = 0;
  logic        cmd_ready = 0;
  logic [31:0] tune_word, decim_m1;
  logic [15:0] scale_i, scale_q;
  logic [63:0] cmd_data;
  logic        cmd_valid, cmd_empty, cmd_full, cmd_overflow, ovr_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_tune, m_scale, m_decim, m_qty;
  logic [63:0] mq [4];
  int          m_cnt;
  bit          m_ovf, m_ovr;

  always #5 clk = ~clk;

  rx_ctrl_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovr_pulse(ovr_pulse), .cmd_ready(cmd_ready), .tune_word(tune_word),
    .scale_i(scale_i), .scale_q(scale_q), .decim_m1(decim_m1),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_empty(cmd_empty),
    .cmd_full(cmd_full), .cmd_overflow(cmd_overflow), .ovr_flag(ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk(tune_word == m_tune, {ctx, " R2 tune"}, 64'(tune_word), 64'(m_tune));
    chk({scale_i, scale_q} == m_scale, {ctx, " R3 scale"}, 64'({scale_i, scale_q}), 64'(m_scale));
    chk(decim_m1 == m_decim, {ctx, " R4 decim"}, 64'(decim_m1), 64'(m_decim));
    chk(cmd_valid == (m_cnt > 0) && cmd_empty == (m_cnt == 0) && cmd_full == (m_cnt == 4),
        {ctx, " R7 fifo flags"}, 64'({cmd_valid, cmd_empty, cmd_full}),
        64'({m_cnt > 0, m_cnt == 0, m_cnt == 4}));
    if (m_cnt > 0)
      chk(cmd_data == mq[0], {ctx, " R6 head"}, cmd_data, mq[0]);
    chk(cmd_overflow == m_ovf, {ctx, " R8 overflow"}, 64'(cmd_overflow), 64'(m_ovf));
    chk(ovr_flag == m_ovr, {ctx, " R9 overrun"}, 64'(ovr_flag), 64'(m_ovr));
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input bit rdy, input bit os, input string ctx);
    bit popped, clr;
    logic [31:0] q_before;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; cmd_ready = rdy; ovr_pulse = os;
    popped = rdy && (m_cnt > 0);
    clr = 0;
    q_before = m_qty;
    if (popped) begin
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      m_cnt--;
    end
    if (we) begin
      case (a)
        8'd160: m_tune = d;
        8'd161: m_scale = d;
        8'd162: m_decim = d;
        8'd164: m_qty = d;
        8'd163: begin
          if (m_cnt < 4) begin mq[m_cnt] = {d, q_before}; m_cnt++; end
          else m_ovf = 1;
        end
        8'd165: clr = 1;
        default: ;
      endcase
    end
    if (os) m_ovr = 1;
    else if (clr) m_ovr = 0;
    @(negedge clk);
    wr_en = 0; cmd_ready = 0; ovr_pulse = 0;
    check_all(ctx);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    m_tune = 0; m_scale = 0; m_decim = 0; m_qty = 0; m_cnt = 0; m_ovf = 0; m_ovr = 0;
    for (int i = 0; i < 4; i++) mq[i] = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 0;

    // R10: full address sweep; model changes only inside 160..165
    step(1, 8'd164, 32'h0000_1234, 0, 0, "R5 stage");
    for (int a = 0; a < 256; a++)
      step(1, 8'(a), 32'h9E37_79B9 * 32'(a + 1), 0, 0, "R10 sweep");

    // R10: strobe low at a window address
    step(0, 8'd160, 32'hDEAD_BEEF, 0, 0, "R10 no strobe");

    // R7: drain, then pop while empty
    while (m_cnt > 0) step(0, 8'd0, 0, 1, 0, "R7 drain");
    step(0, 8'd0, 0, 1, 0, "R7 pop empty");

    // R5: staging alone pushes nothing
    step(1, 8'd164, {23'h12345, 9'h0AB}, 0, 0, "R5 stage only");
    chk(cmd_empty == 1'b1, "R5 no push", 64'(cmd_empty), 64'd1);

    // R6/R7: fill with four distinct commands, ordered drain
    for (int k = 0; k < 4; k++) begin
      step(1, 8'd164, {23'(k * 7 + 1), 9'(k + 3)}, 0, 0, "R5 stage");
      step(1, 8'd163, 32'h1000_0000 + 32'(k), 0, 0, "R6 push");
    end
    chk(cmd_full == 1'b1, "R7 full at four", 64'(cmd_full), 64'd1);

    // R8: push when full and no pop is dropped
    step(1, 8'd163, 32'hBAD0_0000, 0, 0, "R8 drop");
    chk(cmd_overflow == 1'b1, "R8 flag set", 64'(cmd_overflow), 64'd1);
    // R8: push with pop while full
    step(1, 8'd163, 32'h5555_0000, 1, 0, "R8 swap");
    for (int k = 0; k < 4; k++) step(0, 8'd0, 0, 1, 0, "R7 ordered drain");
    chk(cmd_empty == 1'b1, "R7 empty after drain", 64'(cmd_empty), 64'd1);

    // R9: overrun set, clear with arbitrary data, simultaneous set/clear
    step(0, 8'd0, 0, 0, 1, "R9 set");
    step(1, 8'd165, 32'h0000_0000, 0, 0, "R9 clear zero");
    step(0, 8'd0, 0, 0, 1, "R9 set again");
    step(1, 8'd165, 32'hFFFF_FFFF, 0, 0, "R9 clear ones");
    step(1, 8'd165, 32'h1, 0, 1, "R9 set wins");
    chk(ovr_flag == 1'b1, "R9 set wins", 64'(ovr_flag), 64'd1);

    // R3: scale field split sweep
    for (int v = 0; v < 64; v++)
      step(1, 8'd161, {16'(v * 1021), 16'(16'hFFFF - v * 37)}, 0, 0, "R3 scale");

    // mixed traffic from an LFSR
    lf = 32'hACE1_1234;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf[3] ? 8'(160 + (lf[6:4] % 6)) : lf[15:8];
      step(lf[0], a, lf ^ 32'(n), lf[1] & lf[2], lf[9] & lf[10] & lf[11], "R6 R7 mixed");
    end

    // R1: reset again from a busy state
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    m_tune = 0; m_scale = 0; m_decim = 0; m_qty = 0; m_cnt = 0; m_ovf = 0; m_ovr = 0;
    check_all("R1 re-reset");
    step(1, 8'd163, 32'h7777_0000, 0, 0, "R1 staged qty cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule